// File: doc/BRIEF.md
# Sticky Interrupt Status Gate

This block collects event pulses from the FIFOs and the descriptor engine of a serial flash controller. It holds them in sticky status bits and drives one interrupt line. Capture passes through two masks. The enable mask decides whether an event is recorded in status at all. The signal-enable mask then decides which recorded events may raise the line.

Software reads the status word to learn what happened. A read of all zeros means nothing is pending. Software clears a bit by writing 1 to it. To quiet the line while keeping the record, software clears the enable bit of that event.

A pulse on the soft-reset input flushes the FIFOs. It therefore raises the two "FIFO empty" events, and these are captured like any other event.

Top module: `irq_status_gate`

## Requirements
- R1: After a synchronous active-low reset, the status, enable and signal-enable registers all read 0 and the interrupt line is low.
- R2: An event pulse on a bit whose enable bit is 1 sets that status bit. It reads back as 1 in the cycle after the capturing edge. The implemented bits are 0 TX empty, 1 TX full, 2 TX threshold, 3 RX empty, 4 RX full, 5 RX threshold, 9 descriptor done, 10 packet complete and 11 DMA error.
- R3: An event pulse on a bit whose enable bit is 0 leaves that status bit unchanged.
- R4: A set status bit stays set after its event ends, and it stays set even when its enable bit is later cleared. Only a clear write removes it.
- R5: A write to status clears every status bit written as 1 and leaves bits written as 0 unchanged.
- R6: When an enabled event and a clear of the same bit happen in the same cycle, the bit ends up set.
- R7: The interrupt line is high exactly when some bit is 1 in status, enable and signal-enable together. Writing 0 to the enable bits drops the line in the cycle after the write edge.
- R8: A recorded status bit whose signal-enable bit is 0 does not drive the interrupt line.
- R9: A soft-reset pulse raises the TX empty (bit 0) and RX empty (bit 3) events. Each is recorded when its enable bit is 1.
- R10: Bit positions 6, 7, 8 and 12 to 31 always read 0. Writes to them are ignored, and event pulses on them are never recorded.
- R11: The enable register is at byte offset 0x1C, status at 0x20 and signal-enable at 0x58. A read of any other offset returns 0, and a write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 32 | One-cycle event pulses, one per status bit |
| soft_rst | input | 1 | Controller soft-reset pulse; raises the FIFO-empty events |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| irq | output | 1 | Interrupt line |

## Verification
Every register update takes effect at the clock edge that samples the write or the event, so status, enable and signal-enable read back changed one cycle after the stimulus is applied. The line follows the registers without further delay, so it also changes in that cycle. The read port is combinational, so a read returns the current register value in the same cycle. The bench drives each stimulus on the falling edge and advances its own register model at the rising edge. It compares the read data and the line a short delay after that rising edge, which is the first moment either result is due.

// File: rtl/isg_pkg.sv
// Shared constants for the sticky interrupt status gate: bit positions,
// register offsets and the mask of implemented status bits.
package isg_pkg;
    localparam int ISG_DW = 32;
    localparam int ISG_AW = 8;

    localparam int B_TX_EMPTY  = 0;
    localparam int B_TX_FULL   = 1;
    localparam int B_TX_THR    = 2;
    localparam int B_RX_EMPTY  = 3;
    localparam int B_RX_FULL   = 4;
    localparam int B_RX_THR    = 5;
    localparam int B_DESC_DONE = 9;
    localparam int B_PKT_DONE  = 10;
    localparam int B_DMA_ERR   = 11;

    localparam logic [ISG_AW-1:0] OFS_ENABLE = 8'h1C;
    localparam logic [ISG_AW-1:0] OFS_STATUS = 8'h20;
    localparam logic [ISG_AW-1:0] OFS_SIGNAL = 8'h58;

    localparam logic [ISG_DW-1:0] ISG_VALID =
        (ISG_DW'(1) << B_TX_EMPTY) | (ISG_DW'(1) << B_TX_FULL) |
        (ISG_DW'(1) << B_TX_THR)   | (ISG_DW'(1) << B_RX_EMPTY) |
        (ISG_DW'(1) << B_RX_FULL)  | (ISG_DW'(1) << B_RX_THR) |
        (ISG_DW'(1) << B_DESC_DONE) | (ISG_DW'(1) << B_PKT_DONE) |
        (ISG_DW'(1) << B_DMA_ERR);

    localparam logic [ISG_DW-1:0] ISG_SRST_EVT =
        (ISG_DW'(1) << B_TX_EMPTY) | (ISG_DW'(1) << B_RX_EMPTY);
endpackage

// File: rtl/isg_mask_reg.sv
// Writable mask register (used for both enable and signal-enable).
// Assumes wr_stb is already decoded for this register's offset.
// Bits outside VALID_MASK are not stored and read as 0.
module isg_mask_reg #(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] VALID_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (VALID_MASK[i]) begin : g_flop
            // Holds one mask bit; reloaded on a decoded write.
            always_ff @(posedge clk) begin
                if (!rst_n)      q[i] <= 1'b0;
                else if (wr_stb) q[i] <= wr_data[i];
            end
        end else begin : g_tie
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/isg_sticky_bank.sv
// Sticky status bits with write-one-to-clear. A set request in the same
// cycle as a clear wins. Assumes set_req is already qualified by enable.
module isg_sticky_bank #(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] VALID_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_req,
    input  logic [DATA_W-1:0] clr_req,
    output logic [DATA_W-1:0] status
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (VALID_MASK[i]) begin : g_flop
            // One sticky bit: set has priority, clear only on written 1.
            always_ff @(posedge clk) begin
                if (!rst_n)          status[i] <= 1'b0;
                else if (set_req[i]) status[i] <= 1'b1;
                else if (clr_req[i]) status[i] <= 1'b0;
            end
        end else begin : g_tie
            assign status[i] = 1'b0;
        end
    end
endmodule

// File: rtl/isg_decode.sv
// Register-port decode: write strobes per register, clear vector for the
// status register, and the combinational read multiplexer.
// Unmapped offsets read 0 and produce no strobe.
module isg_decode #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] A_ENABLE = '0,
    parameter logic [ADDR_W-1:0] A_STATUS = '0,
    parameter logic [ADDR_W-1:0] A_SIGNAL = '0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] en_q,
    input  logic [DATA_W-1:0] st_q,
    input  logic [DATA_W-1:0] sg_q,
    output logic              en_stb,
    output logic              sg_stb,
    output logic [DATA_W-1:0] st_clr,
    output logic [DATA_W-1:0] rd_data
);
    // Decodes the write offset into per-register strobes.
    always_comb begin
        en_stb = wr_en && (wr_addr == A_ENABLE);
        sg_stb = wr_en && (wr_addr == A_SIGNAL);
        st_clr = (wr_en && (wr_addr == A_STATUS)) ? wr_data : '0;
    end

    // Selects the register addressed by rd_addr; unmapped reads give 0.
    always_comb begin
        unique case (rd_addr)
            A_ENABLE: rd_data = en_q;
            A_STATUS: rd_data = st_q;
            A_SIGNAL: rd_data = sg_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/isg_line_gate.sv
// Two-stage gate in front of the interrupt line: a status bit drives the
// line only when both its enable and signal-enable bits are 1.
module isg_line_gate #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] enable,
    input  logic [DATA_W-1:0] sig_en,
    output logic              irq
);
    // Reduces the doubly gated status vector to the line.
    always_comb irq = |(status & enable & sig_en);
endmodule

// File: rtl/irq_status_gate.sv
// Top of the sticky interrupt status gate. Qualifies event pulses (and the
// soft-reset events) with the enable mask, keeps them sticky, and gates the
// interrupt line through the signal-enable mask. Assumes event pulses and
// register writes are synchronous to clk.
module irq_status_gate
    import isg_pkg::*;
#(
    parameter int DATA_W = ISG_DW,
    parameter int ADDR_W = ISG_AW,
    parameter logic [DATA_W-1:0] VALID_MASK = ISG_VALID,
    parameter logic [DATA_W-1:0] SRST_EVENTS = ISG_SRST_EVT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_pulse,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [DATA_W-1:0] en_q, sg_q, st_q, st_clr, set_req;
    logic              en_stb, sg_stb;

    isg_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .A_ENABLE(OFS_ENABLE), .A_STATUS(OFS_STATUS), .A_SIGNAL(OFS_SIGNAL)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .en_q(en_q), .st_q(st_q), .sg_q(sg_q),
        .en_stb(en_stb), .sg_stb(sg_stb), .st_clr(st_clr), .rd_data(rd_data)
    );

    isg_mask_reg #(.DATA_W(DATA_W), .VALID_MASK(VALID_MASK)) u_enable (
        .clk(clk), .rst_n(rst_n), .wr_stb(en_stb), .wr_data(wr_data), .q(en_q)
    );

    isg_mask_reg #(.DATA_W(DATA_W), .VALID_MASK(VALID_MASK)) u_sigen (
        .clk(clk), .rst_n(rst_n), .wr_stb(sg_stb), .wr_data(wr_data), .q(sg_q)
    );

    // Merges soft-reset events with event pulses and applies the enable mask.
    always_comb set_req = (evt_pulse | (soft_rst ? SRST_EVENTS : '0)) & en_q;

    isg_sticky_bank #(.DATA_W(DATA_W), .VALID_MASK(VALID_MASK)) u_status (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(st_clr),
        .status(st_q)
    );

    isg_line_gate #(.DATA_W(DATA_W)) u_gate (
        .status(st_q), .enable(en_q), .sig_en(sg_q), .irq(irq)
    );
endmodule

// File: rtl/irq_status_gate_chk.sv
// Property checker for irq_status_gate, attached by bind. Observes the
// register port, the event inputs and the three internal registers.
module irq_status_gate_chk
    import isg_pkg::*;
#(
    parameter int DATA_W = ISG_DW,
    parameter int ADDR_W = ISG_AW,
    parameter logic [DATA_W-1:0] VALID_MASK = ISG_VALID,
    parameter logic [DATA_W-1:0] SRST_EVENTS = ISG_SRST_EVT
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] evt_pulse,
    input logic              soft_rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq,
    input logic [DATA_W-1:0] en_q,
    input logic [DATA_W-1:0] sg_q,
    input logic [DATA_W-1:0] st_q
);
    logic [DATA_W-1:0] cause_v, clr_v;
    logic              mask_off_wr;

    // Recomputes enabled causes and clears from the port view.
    always_comb begin
        cause_v     = (evt_pulse | (soft_rst ? SRST_EVENTS : '0)) & en_q;
        clr_v       = (wr_en && wr_addr == OFS_STATUS) ? wr_data : '0;
        mask_off_wr = wr_en && (wr_addr == OFS_ENABLE) &&
                      ((wr_data & VALID_MASK) == '0);
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (st_q == '0 && en_q == '0 && sg_q == '0 && !irq));

    a_r3_capture_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & ~$past(st_q) & ~$past(cause_v)) == '0));

    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q) & ~$past(clr_v) & ~st_q) == '0));

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(cause_v) & ~st_q) == '0));

    a_r7_quiet_after_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
        mask_off_wr |=> !irq);

    a_r8_signal_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (sg_q == '0) |-> !irq);
endmodule

bind irq_status_gate irq_status_gate_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .VALID_MASK(VALID_MASK), .SRST_EVENTS(SRST_EVENTS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq),
    .en_q(en_q), .sg_q(sg_q), .st_q(st_q)
);

// File: tb/sim_irq_status_gate.sv
module sim_irq_status_gate;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VALID = 32'h0000_0E3F;
    localparam logic [31:0] SRSTV = 32'h0000_0009;
    localparam logic [7:0]  A_EN = 8'h1C, A_ST = 8'h20, A_SG = 8'h58, A_NONE = 8'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_pulse = '0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] m_st = '0, m_en = '0, m_sg = '0;

    irq_status_gate u0 (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] f_read(input logic [7:0] a);
        case (a)
            A_EN:    return m_en;
            A_ST:    return m_st;
            A_SG:    return m_sg;
            default: return '0;
        endcase
    endfunction

    function automatic logic [31:0] f_next_st(input logic [31:0] st, en,
            ev, input logic sr, input logic [31:0] clr);
        return ((st & ~clr) | ((ev | (sr ? SRSTV : '0)) & en)) & VALID;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, advance model at posedge, compare after it.
    task automatic cyc(input logic we, input logic [7:0] wa, input logic [31:0] wd,
            input logic [31:0] ev, input logic sr, input logic [7:0] ra,
            input string tag);
        logic [31:0] clr;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; evt_pulse = ev;
        soft_rst = sr; rd_addr = ra;
        clr = (we && wa == A_ST) ? wd : '0;
        @(posedge clk);
        m_st = f_next_st(m_st, m_en, ev, sr, clr);
        if (we && wa == A_EN) m_en = wd & VALID;
        if (we && wa == A_SG) m_sg = wd & VALID;
        #1;
        check({tag, " rd"}, rd_data, f_read(ra));
        check({tag, " irq"}, {31'd0, irq}, {31'd0, |(m_st & m_en & m_sg)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        // R1 reset state, R11 map
        cyc(0, A_EN, 0, 0, 0, A_EN, "R1 en");
        @(negedge clk); rst_n = 1'b1;
        cyc(0, A_EN, 0, 0, 0, A_ST, "R1 st");
        cyc(0, A_EN, 0, 0, 0, A_SG, "R1 sg");
        // R10 unused bits ignore writes
        cyc(1, A_EN, 32'hFFFF_FFFF, 0, 0, A_EN, "R10 en write");
        cyc(1, A_SG, 32'hFFFF_FFFF, 0, 0, A_SG, "R10 sg write");
        check("R10 en value", f_read(A_EN), 32'h0000_0E3F);
        // R2 capture, R7 line
        cyc(0, A_EN, 0, 32'h0000_0200, 0, A_ST, "R2 capture");
        check("R2 status", rd_data, 32'h0000_0200);
        check("R7 line high", {31'd0, irq}, 32'd1);
        // R4 sticky
        cyc(0, A_EN, 0, 0, 0, A_ST, "R4 hold");
        cyc(1, A_EN, 0, 0, 0, A_ST, "R7 mask off");
        check("R7 line low", {31'd0, irq}, 32'd0);
        check("R4 kept", rd_data, 32'h0000_0200);
        // R3 masked event not captured
        cyc(0, A_EN, 0, 32'h0000_0400, 0, A_ST, "R3 masked");
        check("R3 status", rd_data, 32'h0000_0200);
        // R5 write-one-to-clear
        cyc(1, A_ST, 32'h0000_0001, 0, 0, A_ST, "R5 zero bits keep");
        check("R5 keep", rd_data, 32'h0000_0200);
        cyc(1, A_ST, 32'h0000_0200, 0, 0, A_ST, "R5 clear");
        check("R5 cleared", rd_data, 32'h0);
        // R8 signal gate
        cyc(1, A_EN, 32'h0000_0E3F, 0, 0, A_EN, "R8 en");
        cyc(1, A_SG, 32'h0000_0001, 0, 0, A_SG, "R8 sg");
        cyc(0, A_EN, 0, 32'h0000_0010, 0, A_ST, "R8 gated");
        check("R8 line low", {31'd0, irq}, 32'd0);
        // R6 set wins over clear
        cyc(1, A_ST, 32'h0000_0010, 32'h0000_0010, 0, A_ST, "R6 set wins");
        check("R6 status", rd_data, 32'h0000_0010);
        // R9 soft reset events
        cyc(0, A_EN, 0, 0, 1, A_ST, "R9 soft reset");
        check("R9 status", rd_data, 32'h0000_0019);
        check("R9 line", {31'd0, irq}, 32'd1);
        // R10 unused event position
        cyc(0, A_EN, 0, 32'hFFFF_F1C0, 0, A_ST, "R10 unused events");
        check("R10 status", rd_data, 32'h0000_0019);
        // R11 unmapped offset
        cyc(1, A_NONE, 32'hFFFF_FFFF, 0, 0, A_NONE, "R11 unmapped read");
        cyc(0, A_EN, 0, 0, 0, A_EN, "R11 en unchanged");
        cyc(0, A_EN, 0, 0, 0, A_SG, "R11 sg unchanged");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] addr_set [4];
            logic we; logic [7:0] wa, ra; logic [31:0] wd, ev; logic sr;
            addr_set[0] = A_EN; addr_set[1] = A_ST; addr_set[2] = A_SG; addr_set[3] = A_NONE;
            we = ($urandom % 4) == 0;
            wa = addr_set[$urandom % 4];
            ra = addr_set[$urandom % 4];
            wd = $urandom & $urandom;
            ev = $urandom & $urandom & $urandom;
            sr = ($urandom % 32) == 0;
            cyc(we, wa, wd, ev, sr, ra, "RND R2/R5/R7");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule